// File: doc/BRIEF.md
# Fractional Horizontal Pixel Upscaler

This block widens each video line by a programmable ratio between exactly one and just under two. Pixels come in from a frame-store reader over a valid/ready handshake. Each line is framed by a first-pixel flag and a last-pixel flag. The block emits a longer line on a second valid/ready stream, and that line carries the same two flags. A 6-bit coefficient `m` sets the ratio to `1 + m/64`. Software writes the coefficient through a small register-write port.

Inside, a fixed-point phase accumulator with 12 fractional bits advances by `floor(2^18 / (64 + m))` for every output pixel. Each time its integer part steps, one input pixel is retired. Each output pixel is a linear mix of the current input pixel and the one after it. The top six fractional phase bits weight the mix. A two-entry pixel window feeds the mix. The block stalls its input while it is still producing extra pixels from the window it holds. The accumulator and the step size are reloaded at every line start, so no rounding error and no coefficient change can reach into a line already under way.

Top module: `hscale_upscaler`

## Requirements
- R1: While reset is asserted, and until the internal reset release has completed, `in_ready` and `out_valid` are 0. The coefficient resets to 0, which means unity scaling.
- R2: A cycle with `cfg_we` high and `cfg_addr` equal to 0x24 loads `cfg_wdata[5:0]` as the coefficient `m`. A write to any other address changes nothing.
- R3: A line of N input pixels uses the step `s = floor(262144 / (64 + m))`. It yields exactly one output pixel for each k ≥ 0 with `k*s < N*4096`, and no others.
- R4: Output pixel k uses phase `P = k*s`, index `i = P >> 12` and weight `f = (P >> 6) & 63`. Its value is `(p[i]*(64-f) + p[i+1]*f) >> 6`, truncated.
- R5: With m = 0 the output line equals the input line, pixel for pixel.
- R6: For the last input pixel of a line, `p[i+1]` is taken to be that same last pixel.
- R7: `out_sol` is 1 on exactly the first output pixel of a line. `out_eol` is 1 on exactly the last one.
- R8: The phase restarts at zero at every line start, so each line's output depends only on that line's pixels and its step.
- R9: The coefficient is captured when a line's first pixel is accepted. A write made during a line affects only later lines.
- R10: `in_ready` is 0 while the output is stalled with a pixel pending. With m = 0 and a consumer that is always ready, the input is never stalled.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_pix`, `out_sol` and `out_eol` hold their values into the next cycle, and `out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (8) | Register write address |
| cfg_wdata | input | 6 | Coefficient value to write |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take an input pixel |
| in_pix | input | PIX_W (8) | Input pixel value |
| in_sol | input | 1 | Input pixel is the first of its line |
| in_eol | input | 1 | Input pixel is the last of its line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_pix | output | PIX_W (8) | Scaled pixel value |
| out_sol | output | 1 | Output pixel is the first of its line |
| out_eol | output | 1 | Output pixel is the last of its line |

## Verification
The cycle-level properties are asserted on every cycle:
- outputs hold steady under a stall;
- input is refused while an output waits;
- the step is recaptured only when a line's first pixel is accepted, and stays within its legal range;
- the line after an end marker opens with a start marker.

Only the bench's scenarios can show that the pixel values, the output counts per line and the edge replication at the line end match the arithmetic. The same holds for the deferred effect of a write made during a line. The bench covers these by sweeping every coefficient value over short lines under several stall patterns.

// File: rtl/hscale_pkg.sv
package hscale_pkg;

  localparam int unsigned COEF_W = 6;
  localparam int unsigned FRAC_W = 12;
  localparam int unsigned STEP_W = FRAC_W + 1;

  typedef logic [COEF_W-1:0] coef_t;
  typedef logic [FRAC_W-1:0] frac_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam step_t STEP_UNITY = step_t'(1) << FRAC_W;
  localparam step_t STEP_MIN   = step_t'((1 << (FRAC_W + COEF_W)) / ((2 << COEF_W) - 1));

endpackage

// File: rtl/hscale_coef_reg.sv
module hscale_coef_reg
  import hscale_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  COEF_ADDR = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  coef_t             wdata,
  output coef_t             coef
);

  logic  wr_en;
  coef_t coef_q;

  assign wr_en = we & (addr == COEF_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= '0;
    end else if (wr_en) begin
      coef_q <= wdata;
    end
  end

  assign coef = coef_q;

endmodule

// File: rtl/hscale_step_div.sv
module hscale_step_div
  import hscale_pkg::*;
(
  input  coef_t coef,
  output step_t step
);

  localparam int unsigned NW = FRAC_W + COEF_W + 1;
  localparam logic [NW-1:0] NUM = NW'(1) << (NW - 1);

  logic [NW-1:0] den;

  // ratio 1 + m/64 -> input advance per output = 64/(64+m) of a pixel
  always_comb begin
    den  = NW'({1'b1, coef});
    step = STEP_W'(NUM / den);
  end

endmodule

// File: rtl/hscale_blend.sv
module hscale_blend
  import hscale_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0]  near_pix,
  input  logic [PIX_W-1:0]  far_pix,
  input  coef_t             weight,
  output logic [PIX_W-1:0]  mix_pix
);

  localparam int unsigned AW = PIX_W + COEF_W + 1;

  logic [AW-1:0] near_x, far_x, w_far, w_near, acc;

  always_comb begin
    near_x  = AW'(near_pix);
    far_x   = AW'(far_pix);
    w_far   = AW'(weight);
    w_near  = AW'(1 << COEF_W) - w_far;
    acc     = near_x * w_near + far_x * w_far;
    mix_pix = acc[COEF_W +: PIX_W];
  end

endmodule

// File: rtl/hscale_upscaler.sv
module hscale_upscaler
  import hscale_pkg::*;
#(
  parameter int unsigned       PIX_W     = 8,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] COEF_ADDR = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [5:0]        cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_sol,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_sol,
  output logic              out_eol
);

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign run_q = rst_sync_q[1];

  coef_t coef;
  step_t step_new;

  hscale_coef_reg #(.ADDR_W(ADDR_W), .COEF_ADDR(COEF_ADDR)) u_coef (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .coef  (coef)
  );

  hscale_step_div u_div (
    .coef (coef),
    .step (step_new)
  );

  // two-pixel window: slot a is current, slot b is the next one
  logic [PIX_W-1:0] a_pix_q, a_pix_d, b_pix_q, b_pix_d;
  logic             a_sol_q, a_sol_d, a_last_q, a_last_d, a_vld_q, a_vld_d;
  logic             b_last_q, b_last_d, b_vld_q, b_vld_d;
  frac_t            frac_q, frac_d;
  step_t            step_q, step_d;
  logic             win_en, phase_en;

  step_t            sum;
  logic             wrap, out_fire, in_fire, adv;
  logic             sa_vld, sa_last, sb_vld;
  logic [PIX_W-1:0] far_pix;

  always_comb begin
    out_valid = a_vld_q & (b_vld_q | a_last_q);
    far_pix   = b_vld_q ? b_pix_q : a_pix_q;
    sum       = step_t'(frac_q) + step_q;
    wrap      = sum[FRAC_W];
    out_fire  = out_valid & out_ready;
    adv       = out_fire & wrap;
    out_sol   = a_sol_q & (frac_q == '0);
    out_eol   = a_last_q & wrap;

    // window occupancy once this cycle's retirement is applied
    sa_vld    = adv ? b_vld_q  : a_vld_q;
    sa_last   = adv ? b_last_q : a_last_q;
    sb_vld    = b_vld_q & ~adv;
    in_ready  = run_q & ~sb_vld & ~(sa_vld & sa_last);
    in_fire   = in_valid & in_ready;
  end

  hscale_blend #(.PIX_W(PIX_W)) u_blend (
    .near_pix (a_pix_q),
    .far_pix  (far_pix),
    .weight   (frac_q[FRAC_W-1 -: COEF_W]),
    .mix_pix  (out_pix)
  );

  always_comb begin
    a_pix_d  = a_pix_q;
    a_sol_d  = a_sol_q;
    a_last_d = a_last_q;
    a_vld_d  = a_vld_q;
    b_pix_d  = b_pix_q;
    b_last_d = b_last_q;
    b_vld_d  = b_vld_q;
    frac_d   = frac_q;
    step_d   = step_q;

    if (adv) begin
      a_pix_d  = b_pix_q;
      a_sol_d  = 1'b0;
      a_last_d = b_last_q;
      a_vld_d  = b_vld_q;
      b_vld_d  = 1'b0;
    end
    if (out_fire) begin
      frac_d = (adv & a_last_q) ? '0 : sum[FRAC_W-1:0];
    end
    if (in_fire) begin
      if (!sa_vld) begin
        a_pix_d  = in_pix;
        a_sol_d  = in_sol;
        a_last_d = in_eol;
        a_vld_d  = 1'b1;
        if (in_sol) begin
          frac_d = '0;
          step_d = step_new;
        end
      end else begin
        b_pix_d  = in_pix;
        b_last_d = in_eol;
        b_vld_d  = 1'b1;
      end
    end

    win_en   = out_fire | in_fire;
    phase_en = out_fire | (in_fire & in_sol & ~sa_vld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_pix_q  <= '0;
      a_sol_q  <= 1'b0;
      a_last_q <= 1'b0;
      a_vld_q  <= 1'b0;
      b_pix_q  <= '0;
      b_last_q <= 1'b0;
      b_vld_q  <= 1'b0;
    end else if (!run_q) begin
      a_vld_q  <= 1'b0;
      b_vld_q  <= 1'b0;
    end else if (win_en) begin
      a_pix_q  <= a_pix_d;
      a_sol_q  <= a_sol_d;
      a_last_q <= a_last_d;
      a_vld_q  <= a_vld_d;
      b_pix_q  <= b_pix_d;
      b_last_q <= b_last_d;
      b_vld_q  <= b_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      step_q <= STEP_UNITY;
    end else if (run_q && phase_en) begin
      frac_q <= frac_d;
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/hscale_upscaler_chk.sv
module hscale_upscaler_chk
  import hscale_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sol,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_sol,
  input logic             out_eol,
  input step_t            step_q
);

  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_sol) && $stable(out_eol));

  a_r10_block_input_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r9_step_only_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_q) |-> $past(in_valid && in_ready && in_sol));

  a_r3_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q <= STEP_UNITY) && (step_q >= STEP_MIN));

  a_r7_line_opens_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eol |=> !out_valid || out_sol);

endmodule

bind hscale_upscaler hscale_upscaler_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sol    (in_sol),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .out_sol   (out_sol),
  .out_eol   (out_eol),
  .step_q    (step_q)
);

// File: tb/hscale_upscaler_test.sv
`timescale 1ns/1ps
module hscale_upscaler_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_addr;
  logic [5:0] cfg_wdata;
  logic       in_valid, in_ready, in_sol, in_eol;
  logic [7:0] in_pix;
  logic       out_valid, out_ready, out_sol, out_eol;
  logic [7:0] out_pix;

  int checks = 0;
  int errors = 0;
  int wd     = 0;
  int last_stall;

  always #2 clk = ~clk;

  hscale_upscaler uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_sol(in_sol), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sol(out_sol), .out_eol(out_eol)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic write_reg(input int addr, input int val);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 8'(addr);
    cfg_wdata = 6'(val);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // m: coefficient expected to govern this line; seed selects stalls and data
  task automatic run_line(input int m, input int n, input int seed, input int mid_val,
                          input string req);
    int inp[16];
    int ep[40];
    bit es[40], ee[40];
    int s, cnt, got, sent, cyc, hp;
    bit hold, hs, he;
    s = 262144 / (64 + m);
    for (int j = 0; j < n; j++)
      inp[j] = (seed == 2) ? ((j % 2) ? 255 : 0) : ((j * 53 + m * 7 + n * 3 + 17) & 255);
    cnt = 0;
    while (cnt * s < n * 4096) begin
      int p, i, f, a, b;
      p = cnt * s;
      i = p >> 12;
      f = (p >> 6) & 63;
      a = inp[i];
      b = (i + 1 < n) ? inp[i + 1] : inp[i];   // R6 edge replicate
      ep[cnt] = (a * (64 - f) + b * f) >> 6;
      es[cnt] = (cnt == 0);
      ee[cnt] = ((cnt + 1) * s >= n * 4096);
      cnt++;
    end
    got = 0; sent = 0; cyc = 0; hold = 0; hp = 0; hs = 0; he = 0;
    last_stall = 0;
    while ((got < cnt || sent < n) && cyc < 2000) begin
      @(negedge clk);
      if (cyc == 2 && mid_val >= 0) begin
        cfg_we = 1'b1; cfg_addr = 8'h24; cfg_wdata = 6'(mid_val);
      end else begin
        cfg_we = 1'b0;
      end
      out_ready = (seed == 0) ? 1'b1 : (((cyc + seed) % 5) != 3);
      in_valid  = (sent < n) && (seed == 0 || ((cyc + seed) % 7) != 2);
      in_pix    = 8'(inp[(sent < n) ? sent : 0]);
      in_sol    = (sent == 0);
      in_eol    = (sent == n - 1);
      #1;
      if (hold) begin
        chk(out_valid && out_pix == 8'(hp) && out_sol == hs && out_eol == he,
            "R11", "stalled output held", int'(out_pix), hp);
      end
      hold = out_valid && !out_ready;
      hp = int'(out_pix); hs = out_sol; he = out_eol;
      if (in_valid && !in_ready) last_stall++;
      if (out_valid && out_ready) begin
        if (got < cnt) begin
          chk(out_pix == 8'(ep[got]), req, $sformatf("pixel %0d m=%0d", got, m),
              int'(out_pix), ep[got]);
          chk(out_sol == es[got] && out_eol == ee[got], "R7",
              $sformatf("markers pixel %0d m=%0d", got, m),
              int'({out_sol, out_eol}), int'({es[got], ee[got]}));
        end else begin
          chk(1'b0, "R3", "extra output pixel", got + 1, cnt);
        end
        got++;
      end
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    cfg_we    = 1'b0;
    #1;
    chk(got == cnt && !out_valid, "R3", $sformatf("output count m=%0d n=%0d", m, n), got, cnt);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_pix = '0; in_sol = 1'b0; in_eol = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !in_ready, "R1", "outputs during reset", int'({out_valid, in_ready}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!out_valid && in_ready, "R1", "idle after reset", int'({out_valid, in_ready}), 1);

    // coefficient defaults to unity; clean stream must never stall (R10)
    run_line(0, 8, 0, -1, "R5");
    chk(last_stall == 0, "R10", "no stall at unity", last_stall, 0);

    // full coefficient sweep, stall patterns vary (R4, R8)
    for (int m = 0; m < 64; m++) begin
      write_reg(8'h24, m);
      run_line(m, 5 + (m % 4), m % 3, -1, (m == 0) ? "R5" : "R4");
    end

    // single-pixel lines use replicated neighbour (R6)
    write_reg(8'h24, 0);
    run_line(0, 1, 0, -1, "R6");
    write_reg(8'h24, 40);
    run_line(40, 1, 1, -1, "R6");
    run_line(40, 2, 2, -1, "R6");

    // other address ignored (R2)
    write_reg(8'h24, 20);
    write_reg(8'h25, 50);
    write_reg(8'h00, 3);
    run_line(20, 7, 0, -1, "R2");

    // mid-line write deferred to next line (R9)
    write_reg(8'h24, 10);
    run_line(10, 9, 0, 45, "R9");
    run_line(45, 9, 1, -1, "R9");

    // line independence after a different line (R8)
    write_reg(8'h24, 63);
    run_line(63, 12, 2, -1, "R8");
    run_line(63, 3, 0, -1, "R8");

    // back-pressure with interpolation (R10)
    write_reg(8'h24, 32);
    run_line(32, 8, 0, -1, "R4");
    chk(last_stall > 0, "R10", "input stalled while interpolating", last_stall, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule